// File: doc/BRIEF.md
# Buck Converter Mode-Select Controller

This block picks the operating mode of a synchronous step-down converter. It chooses between fixed-frequency PWM operation and hysteretic (pulse-skipping) operation. Every input is a digital flag that has already been sampled: the switch-node polarity taken at the end of each low-side conduction interval, an output-undervoltage flag, a soft-start-complete flag, a low-side reverse-current flag and a switching-clock tick. The comparators, ramp and gate drivers are modelled elsewhere.

The mode only changes after the switch node has shown the same polarity on a run of consecutive switching cycles. This debounce works in both directions. A dip in the output voltage while in hysteretic mode forces PWM on the next clock. Until soft start completes, the mode is held at PWM and power-good stays disabled. Every mode change blanks both gates for one switching period. In hysteretic mode the low side is asked to turn off while current flows in reverse.

Top module: `buck_mode_ctrl`

## Requirements
- R1: With `ss_done` high and the controller in PWM (`mode_hyst`=0), the 8th consecutive accepted sample with `sw_pos`=1 sets `mode_hyst` to 1 at that clock edge. After 7 such samples it is still 0.
- R2: In hysteretic mode (`mode_hyst`=1), the 8th consecutive accepted sample with `sw_pos`=0 clears `mode_hyst` at that clock edge.
- R3: An accepted sample of the opposite polarity restarts the consecutive count from zero. Every mode change also restarts the count.
- R4: A polarity sample is accepted only in a clock cycle where `smp_strobe` and `cyc_tick` are both 1. A strobe without a tick, or a tick without a strobe, neither counts nor restarts the count.
- R5: If `uv_flag` is 1 in hysteretic mode, `mode_hyst` is 0 after the next clock edge, no matter what the count holds.
- R6: While `ss_done` is 0, `mode_hyst` is forced to 0 at the next edge, samples are not counted, and `pgood_en` is 0. `pgood_en` equals `ss_done` delayed by one clock.
- R7: `gate_blank` goes to 1 at the clock edge where `mode_hyst` changes. It returns to 0 at the edge where the next `cyc_tick` is seen, which is one switching period for `BLANK_TICKS`=1.
- R8: `ls_off_req` is 1 exactly when `mode_hyst` is 1, `ls_rev` is 1 and `gate_blank` is 0. It follows `ls_rev` in the same cycle.
- R9: A synchronous active-low `rst_n` leaves `mode_hyst`, `gate_blank`, `pgood_en` and `ls_off_req` at 0 and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| smp_strobe | input | 1 | Polarity sample valid (end of low-side conduction) |
| sw_pos | input | 1 | Switch node sampled positive (1) or negative (0) |
| uv_flag | input | 1 | Output below hysteretic regulation threshold |
| ss_done | input | 1 | Soft start has reached its completion level |
| ls_rev | input | 1 | Low-side drain-source shows reverse current |
| mode_hyst | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| gate_blank | output | 1 | Both gate enables forced off |
| pgood_en | output | 1 | Power-good output permitted |
| ls_off_req | output | 1 | Request to switch the low side off |

## Verification
The bench breaks a polarity run one sample short of the threshold and then continues it. A design that forgot to restart the count would switch mode too early. Negative samples offered with a strobe but no tick are placed between two halves of a valid run. A design that accepted them would never enter hysteretic mode. The bench raises undervoltage and drops soft start while in hysteretic mode, and expects PWM one edge later. A slow exit or a missing count clear shows up as a late or spurious mode flip. The blanking window is checked across idle clocks and ends on the following tick, so a window ended by the wrong event is caught.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic {
        MODE_PWM  = 1'b0,
        MODE_HYST = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  pgood;
    } ctrl_st_t;

endpackage

// File: rtl/mode_vote.sv
module mode_vote #(
    parameter int VOTE_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp_ok,
    input  logic agree,
    output logic hit
);
    localparam int CW = (VOTE_CNT > 2) ? $clog2(VOTE_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(VOTE_CNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // run completes on the agreeing sample that would make the count reach VOTE_CNT
    assign hit = smp_ok && agree && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (smp_ok) begin
            if (!agree || hit) cnt_d = '0;
            else               cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
    parameter int BLANK_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic blank
);
    logic blank_d, blank_q;

    generate
        if (BLANK_TICKS <= 1) begin : g_single
            always_comb begin
                blank_d = blank_q;
                if (start)     blank_d = 1'b1;
                else if (tick) blank_d = 1'b0;
            end
        end else begin : g_multi
            localparam int TW = $clog2(BLANK_TICKS);
            localparam logic [TW-1:0] TLAST = TW'(BLANK_TICKS - 1);
            logic [TW-1:0] tcnt_d, tcnt_q;

            always_comb begin
                blank_d = blank_q;
                tcnt_d  = tcnt_q;
                if (start) begin
                    blank_d = 1'b1;
                    tcnt_d  = '0;
                end else if (blank_q && tick) begin
                    if (tcnt_q == TLAST) blank_d = 1'b0;
                    else                 tcnt_d  = tcnt_q + TW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) tcnt_q <= '0;
                else        tcnt_q <= tcnt_d;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b0;
        else        blank_q <= blank_d;
    end

    assign blank = blank_q;
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
    import buck_mode_pkg::*;
#(
    parameter int VOTE_CNT    = 8,
    parameter int BLANK_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic smp_strobe,
    input  logic sw_pos,
    input  logic uv_flag,
    input  logic ss_done,
    input  logic ls_rev,
    output logic mode_hyst,
    output logic gate_blank,
    output logic pgood_en,
    output logic ls_off_req
);
    ctrl_st_t st_d, st_q;
    logic     smp_ok;
    logic     agree;
    logic     vote_hit;
    logic     mode_chg;
    logic     vote_clr;

    // polarity is taken only on a tick-qualified strobe
    assign smp_ok = smp_strobe && cyc_tick && ss_done;
    // pending direction: positive pushes toward hysteretic, negative back to PWM
    assign agree  = (st_q.mode == MODE_PWM) ? sw_pos : !sw_pos;

    always_comb begin
        st_d       = st_q;
        st_d.pgood = ss_done;
        if (!ss_done) begin
            st_d.mode = MODE_PWM;
        end else if (st_q.mode == MODE_HYST && uv_flag) begin
            st_d.mode = MODE_PWM;
        end else if (vote_hit) begin
            st_d.mode = (st_q.mode == MODE_PWM) ? MODE_HYST : MODE_PWM;
        end
        mode_chg = (st_d.mode != st_q.mode);
        vote_clr = mode_chg || !ss_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_PWM;
            st_q.pgood <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    mode_vote #(.VOTE_CNT(VOTE_CNT)) vote_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (vote_clr),
        .smp_ok (smp_ok),
        .agree  (agree),
        .hit    (vote_hit)
    );

    blank_timer #(.BLANK_TICKS(BLANK_TICKS)) blank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mode_chg),
        .tick  (cyc_tick),
        .blank (gate_blank)
    );

    assign mode_hyst  = (st_q.mode == MODE_HYST);
    assign pgood_en   = st_q.pgood;
    assign ls_off_req = mode_hyst && ls_rev && !gate_blank;
endmodule

// File: rtl/buck_mode_ctrl_chk.sv
module buck_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_tick,
    input logic smp_strobe,
    input logic sw_pos,
    input logic uv_flag,
    input logic ss_done,
    input logic ls_rev,
    input logic mode_hyst,
    input logic gate_blank,
    input logic pgood_en,
    input logic ls_off_req
);
    a_r1_entry_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_hyst) |-> $past(smp_strobe && cyc_tick && sw_pos));

    a_r4_no_exit_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_hyst) |-> $past((smp_strobe && cyc_tick && !sw_pos) || uv_flag || !ss_done));

    a_r5_uv_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && uv_flag) |=> !mode_hyst);

    a_r6_softstart_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> (!mode_hyst && !pgood_en));

    a_r7_blank_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst != $past(mode_hyst)) |-> gate_blank);

    a_r8_ls_off_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && ls_rev && !gate_blank) |-> ls_off_req);

    a_r8_ls_off_pwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_hyst |-> !ls_off_req);
endmodule

bind buck_mode_ctrl buck_mode_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_tick   (cyc_tick),
    .smp_strobe (smp_strobe),
    .sw_pos     (sw_pos),
    .uv_flag    (uv_flag),
    .ss_done    (ss_done),
    .ls_rev     (ls_rev),
    .mode_hyst  (mode_hyst),
    .gate_blank (gate_blank),
    .pgood_en   (pgood_en),
    .ls_off_req (ls_off_req)
);

// File: tb/buck_mode_ctrl_tb_top.sv
module buck_mode_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0, smp_strobe = 1'b0, sw_pos = 1'b0;
    logic uv_flag = 1'b0, ss_done = 1'b0, ls_rev = 1'b0;
    logic mode_hyst, gate_blank, pgood_en, ls_off_req;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    buck_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .smp_strobe(smp_strobe),
        .sw_pos(sw_pos), .uv_flag(uv_flag), .ss_done(ss_done), .ls_rev(ls_rev),
        .mode_hyst(mode_hyst), .gate_blank(gate_blank), .pgood_en(pgood_en),
        .ls_off_req(ls_off_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one clock with given strobe/tick/polarity; returns 1 ns after the edge
    task automatic clk1(input logic tk, input logic st, input logic pos);
        @(negedge clk);
        cyc_tick = tk; smp_strobe = st; sw_pos = pos;
        @(posedge clk); #1;
        cyc_tick = 1'b0; smp_strobe = 1'b0;
    endtask

    // one switching period: three idle clocks then a tick carrying a sample
    task automatic period(input logic pos);
        repeat (3) clk1(1'b0, 1'b0, 1'b0);
        clk1(1'b1, 1'b1, pos);
    endtask

    task automatic enter_hyst();
        for (int i = 0; i < 8; i++) period(1'b1);
        period(1'b1); // ends blanking
    endtask

    task automatic t_reset();
        chk("R9 mode", mode_hyst, 1'b0);
        chk("R9 blank", gate_blank, 1'b0);
        chk("R9 pgood", pgood_en, 1'b0);
        chk("R9 lsoff", ls_off_req, 1'b0);
    endtask

    task automatic t_pgood();
        ss_done = 1'b1;
        clk1(1'b0, 1'b0, 1'b0);
        chk("R6 pgood follows", pgood_en, 1'b1);
    endtask

    task automatic t_enter_and_blank();
        for (int i = 0; i < 7; i++) period(1'b1);
        chk("R1 seven not enough", mode_hyst, 1'b0);
        period(1'b1);
        chk("R1 eighth enters", mode_hyst, 1'b1);
        chk("R7 blank on change", gate_blank, 1'b1);
        repeat (3) clk1(1'b0, 1'b0, 1'b0);
        chk("R7 blank held", gate_blank, 1'b1);
        clk1(1'b1, 1'b0, 1'b0);
        chk("R7 blank ends on tick", gate_blank, 1'b0);
    endtask

    task automatic t_ls_off();
        @(negedge clk); ls_rev = 1'b1; #1;
        chk("R8 lsoff on reverse", ls_off_req, 1'b1);
        @(negedge clk); ls_rev = 1'b0; #1;
        chk("R8 lsoff off", ls_off_req, 1'b0);
    endtask

    task automatic t_exit_debounce();
        for (int i = 0; i < 7; i++) period(1'b0);
        period(1'b1);
        for (int i = 0; i < 7; i++) period(1'b0);
        chk("R3 broken run restarts", mode_hyst, 1'b1);
        period(1'b0);
        chk("R2 eighth negative exits", mode_hyst, 1'b0);
        chk("R7 blank on exit", gate_blank, 1'b1);
        @(negedge clk); ls_rev = 1'b1; #1;
        chk("R8 lsoff quiet in PWM", ls_off_req, 1'b0);
        ls_rev = 1'b0;
        period(1'b0);
    endtask

    task automatic t_strobe_qual();
        for (int i = 0; i < 4; i++) period(1'b1);
        for (int i = 0; i < 8; i++) begin
            clk1(1'b0, 1'b1, 1'b0);
            clk1(1'b1, 1'b0, 1'b0);
        end
        chk("R4 untimed samples ignored", mode_hyst, 1'b0);
        for (int i = 0; i < 4; i++) period(1'b1);
        chk("R4 run survives ignored samples", mode_hyst, 1'b1);
        period(1'b1);
    endtask

    task automatic t_uv();
        @(negedge clk); uv_flag = 1'b1;
        @(posedge clk); #1;
        uv_flag = 1'b0;
        chk("R5 uv exits next edge", mode_hyst, 1'b0);
        chk("R5 uv blank", gate_blank, 1'b1);
        period(1'b1);
        for (int i = 0; i < 7; i++) period(1'b1);
        chk("R3 count cleared on change", mode_hyst, 1'b1);
        period(1'b1);
    endtask

    task automatic t_softstart();
        @(negedge clk); ss_done = 1'b0;
        @(posedge clk); #1;
        chk("R6 forced PWM", mode_hyst, 1'b0);
        chk("R6 pgood off", pgood_en, 1'b0);
        for (int i = 0; i < 9; i++) period(1'b1);
        chk("R6 no entry in soft start", mode_hyst, 1'b0);
        ss_done = 1'b1;
        period(1'b1);
    endtask

    task automatic t_reset_mid();
        enter_hyst();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R9 reset mode", mode_hyst, 1'b0);
        chk("R9 reset pgood", pgood_en, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_pgood();
        t_enter_and_blank();
        t_ls_off();
        t_exit_debounce();
        t_strobe_qual();
        t_uv();
        t_softstart();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule